// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor pipeline and a slow RAM. It takes 24-bit physical byte addresses. Each address is split into a tag, a set index and a word-in-line field. Each set holds several ways, and each way stores a valid flag, a dirty flag, a tag and a line of several 32-bit words.

A lookup that hits completes without any stall. A read hit returns its word combinationally in the same cycle. A write hit updates the word and marks the line dirty at the next clock edge.

On a miss the block raises a stall. If the least recently used way of the set is dirty, the block first writes that line back to RAM as a burst. It then burst-reads the requested line into that way. When the stall drops, the processor is still holding its request, so the request hits in that cycle: a read gets its data and a write merges into the new line.

The RAM side uses a request/acknowledge handshake. After the acknowledge, one word moves per strobe, with the words in ascending order from the line base address.

Top module: `wbc_cache`

## Requirements
- R1: Address bits [1:0] select a byte and are ignored. Bits [WORD_BITS+1:2] pick the word in the line, the next SET_BITS bits pick the set, and the remaining upper bits form the tag. A hit needs a valid way in the selected set whose stored tag equals the address tag, so the same tag in a different set misses.
- R2: Reset clears every valid flag. With no request, `req_stall` and `mem_req` are low after reset, and the first access to any line misses.
- R3: A request that hits keeps `req_stall` low in the cycle it is presented, and a read hit drives the stored word on `req_rdata` in that same cycle.
- R4: A write hit updates only the addressed word inside the cache and starts no RAM traffic. Later reads of that word return the written value.
- R5: A request that misses drives `req_stall` high in the cycle it is presented. The stall stays high until the line is filled. In the cycle the stall drops, a held read returns the correct word.
- R6: A fill issues one read request (`mem_we` = 0) whose `mem_addr` is the line base, with the low WORD_BITS+2 bits at zero. It then takes 2^WORD_BITS words on `mem_rvalid`, in ascending word order.
- R7: A newly filled line is clean, so evicting a line that was never written causes no write burst.
- R8: Evicting a dirty line first issues a write request (`mem_we` = 1) at the victim's line base. It then sends 2^WORD_BITS words on `mem_wvalid` in ascending order. Only after that does it issue the read request for the new line.
- R9: The victim within a set is its least recently used way. Every hit and every fill makes the touched way the most recent.
- R10: `mem_req`, `mem_we` and `mem_addr` stay unchanged from the first cycle of a request until the cycle `mem_ack` is sampled high.
- R11: A write that misses fills the line and then merges the written word into it and marks the line dirty, so a later eviction writes the merged word back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present; held while stalled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Physical byte address |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid when request is a read and stall is low |
| req_stall | output | 1 | Processor must hold the request |
| mem_req | output | 1 | RAM burst request |
| mem_we | output | 1 | Burst direction: 1 = write-back, 0 = fill |
| mem_addr | output | 24 | Line base byte address of the burst |
| mem_ack | input | 1 | RAM accepts the request |
| mem_wvalid | output | 1 | Write-back word strobe |
| mem_wdata | output | 32 | Write-back word |
| mem_rvalid | input | 1 | Fill word strobe |
| mem_rdata | input | 32 | Fill word |

## Verification
The bound checker watches the memory side on every cycle. It checks that nothing hits before the first fill word has arrived, that a request holds steady until it is acknowledged, that burst addresses are line-aligned, that any memory activity keeps the processor stalled, and that no write-back sends more than one line of words. Data correctness, the choice of LRU victim, whether a write-back happens for clean or dirty lines, and the merging of a write miss cannot be seen cycle by cycle. Only the bench's scripted access sequences can show them, by comparing read data against a flat memory view and inspecting the captured bursts.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int PA_W   = 24;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_DATA,
    ST_FILL_REQ,
    ST_FILL_DATA
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
  parameter int SET_BITS = 4,
  parameter int WAY_BITS = 2,
  parameter int TAG_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] lk_set,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic [(1<<WAY_BITS)-1:0] hit_vec,
  input  logic [WAY_BITS-1:0] vic_way,
  output logic                vic_valid,
  output logic                vic_dirty,
  output logic [TAG_W-1:0]    vic_tag,
  input  logic                fill_en,
  input  logic [SET_BITS-1:0] fill_set,
  input  logic [WAY_BITS-1:0] fill_way,
  input  logic [TAG_W-1:0]    fill_tag,
  input  logic                mark_en,
  input  logic [SET_BITS-1:0] mark_set,
  input  logic [WAY_BITS-1:0] mark_way
);
  localparam int WAYS = 1 << WAY_BITS;
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][WAYS-1:0] dirty_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];

  // Parallel tag comparators, one per way of the looked-up set
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  assign vic_valid = valid_q[lk_set][vic_way];
  assign vic_dirty = dirty_q[lk_set][vic_way];
  assign vic_tag   = tag_q[lk_set][vic_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_set][fill_way] <= 1'b1;
        dirty_q[fill_set][fill_way] <= 1'b0;
      end
      if (mark_en) begin
        dirty_q[mark_set][mark_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set][fill_way] <= fill_tag;
    end
  end
endmodule

// File: rtl/wbc_lru_rank.sv
module wbc_lru_rank #(
  parameter int SET_BITS = 4,
  parameter int WAY_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set,
  output logic [WAY_BITS-1:0] victim_way,
  input  logic                touch_en,
  input  logic [SET_BITS-1:0] touch_set,
  input  logic [WAY_BITS-1:0] touch_way
);
  localparam int WAYS = 1 << WAY_BITS;
  localparam int SETS = 1 << SET_BITS;
  localparam logic [WAY_BITS-1:0] OLDEST = WAY_BITS'(WAYS - 1);

  // age 0 = most recent, WAYS-1 = least recent; ages in a set are a permutation
  logic [SETS-1:0][WAYS-1:0][WAY_BITS-1:0] age_q;
  logic [WAYS-1:0][WAY_BITS-1:0]           row_cur;
  logic [WAYS-1:0][WAY_BITS-1:0]           row_nxt;

  always_comb begin
    row_cur = age_q[touch_set];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_BITS'(w) == touch_way) begin
        row_nxt[w] = '0;
      end else if (row_cur[w] < row_cur[touch_way]) begin
        row_nxt[w] = row_cur[w] + 1'b1;
      end else begin
        row_nxt[w] = row_cur[w];
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[rd_set][w] == OLDEST) begin
        victim_way = WAY_BITS'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_BITS'(w);
        end
      end
    end else if (touch_en) begin
      age_q[touch_set] <= row_nxt;
    end
  end
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
  parameter int SET_BITS  = 4,
  parameter int WAY_BITS  = 2,
  parameter int WORD_BITS = 2,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic [SET_BITS-1:0]  rd_set,
  input  logic [WAY_BITS-1:0]  rd_way,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [SET_BITS-1:0]  ev_set,
  input  logic [WAY_BITS-1:0]  ev_way,
  input  logic [WORD_BITS-1:0] ev_word,
  output logic [DATA_W-1:0]    ev_data,
  input  logic                 wr_en,
  input  logic [SET_BITS-1:0]  wr_set,
  input  logic [WAY_BITS-1:0]  wr_way,
  input  logic [WORD_BITS-1:0] wr_word,
  input  logic [DATA_W-1:0]    wr_data
);
  localparam int WAYS  = 1 << WAY_BITS;
  localparam int SETS  = 1 << SET_BITS;
  localparam int WORDS = 1 << WORD_BITS;

  logic [DATA_W-1:0] line_q [SETS][WAYS][WORDS];

  assign rd_data = line_q[rd_set][rd_way][rd_word];
  assign ev_data = line_q[ev_set][ev_way][ev_word];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_q[wr_set][wr_way][wr_word] <= wr_data;
    end
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int WAY_BITS  = 2,
  parameter int WORD_BITS = 2,
  parameter int SET_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] req_rdata,
  output logic        req_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  input  logic        mem_ack,
  output logic        mem_wvalid,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int WAYS  = 1 << WAY_BITS;
  localparam int TAG_W = PA_W - SET_BITS - WORD_BITS - 2;
  localparam int OFF_W = WORD_BITS + 2;
  localparam logic [WORD_BITS-1:0] LAST = WORD_BITS'((1 << WORD_BITS) - 1);

  // address fields
  logic [WORD_BITS-1:0] a_word;
  logic [SET_BITS-1:0]  a_set;
  logic [TAG_W-1:0]     a_tag;

  assign a_word = req_addr[2 +: WORD_BITS];
  assign a_set  = req_addr[OFF_W +: SET_BITS];
  assign a_tag  = req_addr[PA_W-1 -: TAG_W];

  // lookup
  logic [WAYS-1:0]     hit_vec;
  logic                hit_any;
  logic [WAY_BITS-1:0] hit_way;
  logic [WAY_BITS-1:0] lru_victim;
  logic                vic_valid;
  logic                vic_dirty;
  logic [TAG_W-1:0]    vic_tag;

  // controller state
  wbc_state_e           state_q, state_d;
  logic [WORD_BITS-1:0] beat_q, beat_d;
  logic [SET_BITS-1:0]  mset_q, mset_d;
  logic [TAG_W-1:0]     mtag_q, mtag_d;
  logic [TAG_W-1:0]     vtag_q, vtag_d;
  logic [WAY_BITS-1:0]  vway_q, vway_d;

  // strobes
  logic hit_use, wr_hit, fill_beat, fill_done;
  logic touch_en;
  logic [SET_BITS-1:0]  touch_set;
  logic [WAY_BITS-1:0]  touch_way;
  logic dw_en;
  logic [SET_BITS-1:0]  dw_set;
  logic [WAY_BITS-1:0]  dw_way;
  logic [WORD_BITS-1:0] dw_word;
  logic [31:0]          dw_data;

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way = WAY_BITS'(w);
      end
    end
  end

  wbc_tag_array #(
    .SET_BITS (SET_BITS),
    .WAY_BITS (WAY_BITS),
    .TAG_W    (TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (a_set),
    .lk_tag    (a_tag),
    .hit_vec   (hit_vec),
    .vic_way   (lru_victim),
    .vic_valid (vic_valid),
    .vic_dirty (vic_dirty),
    .vic_tag   (vic_tag),
    .fill_en   (fill_done),
    .fill_set  (mset_q),
    .fill_way  (vway_q),
    .fill_tag  (mtag_q),
    .mark_en   (wr_hit),
    .mark_set  (a_set),
    .mark_way  (hit_way)
  );

  wbc_lru_rank #(
    .SET_BITS (SET_BITS),
    .WAY_BITS (WAY_BITS)
  ) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_set     (a_set),
    .victim_way (lru_victim),
    .touch_en   (touch_en),
    .touch_set  (touch_set),
    .touch_way  (touch_way)
  );

  wbc_data_array #(
    .SET_BITS  (SET_BITS),
    .WAY_BITS  (WAY_BITS),
    .WORD_BITS (WORD_BITS),
    .DATA_W    (DATA_W)
  ) u_data (
    .clk     (clk),
    .rd_set  (a_set),
    .rd_way  (hit_way),
    .rd_word (a_word),
    .rd_data (req_rdata),
    .ev_set  (mset_q),
    .ev_way  (vway_q),
    .ev_word (beat_q),
    .ev_data (mem_wdata),
    .wr_en   (dw_en),
    .wr_set  (dw_set),
    .wr_way  (dw_way),
    .wr_word (dw_word),
    .wr_data (dw_data)
  );

  // processor-side strobes
  assign hit_use   = (state_q == ST_IDLE) && req_valid && hit_any;
  assign wr_hit    = hit_use && req_write;
  assign fill_beat = (state_q == ST_FILL_DATA) && mem_rvalid;
  assign fill_done = fill_beat && (beat_q == LAST);

  assign touch_en  = hit_use || fill_done;
  assign touch_set = fill_done ? mset_q : a_set;
  assign touch_way = fill_done ? vway_q : hit_way;

  assign dw_en   = fill_beat || wr_hit;
  assign dw_set  = fill_beat ? mset_q    : a_set;
  assign dw_way  = fill_beat ? vway_q    : hit_way;
  assign dw_word = fill_beat ? beat_q    : a_word;
  assign dw_data = fill_beat ? mem_rdata : req_wdata;

  assign req_stall = (state_q != ST_IDLE) || (req_valid && !hit_any);

  // memory-side outputs, all decoded from registered state
  assign mem_req    = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
  assign mem_we     = (state_q == ST_WB_REQ);
  assign mem_wvalid = (state_q == ST_WB_DATA);
  assign mem_addr   = (state_q == ST_WB_REQ) ? {vtag_q, mset_q, {OFF_W{1'b0}}}
                                             : {mtag_q, mset_q, {OFF_W{1'b0}}};

  // next-state logic
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    mset_d  = mset_q;
    mtag_d  = mtag_q;
    vtag_d  = vtag_q;
    vway_d  = vway_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid && !hit_any) begin
          mset_d  = a_set;
          mtag_d  = a_tag;
          vway_d  = lru_victim;
          vtag_d  = vic_tag;
          beat_d  = '0;
          state_d = (vic_valid && vic_dirty) ? ST_WB_REQ : ST_FILL_REQ;
        end
      end
      ST_WB_REQ: begin
        if (mem_ack) state_d = ST_WB_DATA;
      end
      ST_WB_DATA: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == LAST) begin
          state_d = ST_FILL_REQ;
          beat_d  = '0;
        end
      end
      ST_FILL_REQ: begin
        if (mem_ack) state_d = ST_FILL_DATA;
      end
      ST_FILL_DATA: begin
        if (mem_rvalid) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) begin
            state_d = ST_IDLE;
            beat_d  = '0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  // miss context registers, loaded only when a miss is taken
  always_ff @(posedge clk) begin
    if ((state_q == ST_IDLE) && req_valid && !hit_any) begin
      mset_q <= mset_d;
      mtag_q <= mtag_d;
      vtag_q <= vtag_d;
      vway_q <= vway_d;
    end
  end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
  parameter int WORD_BITS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_stall,
  input logic        hit_any,
  input logic        mem_req,
  input logic        mem_we,
  input logic [23:0] mem_addr,
  input logic        mem_ack,
  input logic        mem_wvalid,
  input logic        mem_rvalid
);
  localparam int WORDS = 1 << WORD_BITS;

  logic               fill_seen_q;
  logic [WORD_BITS:0] wb_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_seen_q <= 1'b0;
      wb_cnt_q    <= '0;
    end else begin
      if (mem_rvalid) fill_seen_q <= 1'b1;
      if (mem_req) begin
        wb_cnt_q <= '0;
      end else if (mem_wvalid) begin
        wb_cnt_q <= wb_cnt_q + 1'b1;
      end
    end
  end

  // R2
  no_hit_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_seen_q |-> !hit_any);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  line_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[WORD_BITS+1:0] == '0));

  // R5
  stall_on_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || mem_wvalid || mem_rvalid) |-> req_stall);

  // R8
  wb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (!mem_req && (wb_cnt_q < (WORD_BITS+1)'(WORDS))));
endmodule

bind wbc_cache wbc_cache_chk #(.WORD_BITS(WORD_BITS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_stall  (req_stall),
  .hit_any    (hit_any),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .mem_wvalid (mem_wvalid),
  .mem_rvalid (mem_rvalid)
);

// File: tb/test_wbc_cache.sv
module test_wbc_cache;
  localparam int WORDS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rdata;
  logic        req_stall;
  logic        mem_req, mem_we, mem_wvalid;
  logic [23:0] mem_addr;
  logic        mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wbc_cache i_wbc_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_stall(req_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [23:0] mk(input logic [15:0] t, input logic [3:0] s, input logic [1:0] w);
    return {t, s, w, 2'b00};
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] wa);
    return 32'hC300_0000 | (wa & 32'h00FF_FFFF);
  endfunction

  // RAM model and flat processor view
  logic [31:0] ram    [int];
  logic [31:0] shadow [int];
  logic [31:0] exp_q  [$];

  function automatic logic [31:0] ram_rd(input logic [31:0] wa);
    return ram.exists(int'(wa)) ? ram[int'(wa)] : pat(wa);
  endfunction

  function automatic logic [31:0] view_rd(input logic [23:0] a);
    logic [31:0] wa;
    wa = {10'd0, a[23:2]};
    return shadow.exists(int'(wa)) ? shadow[int'(wa)] : pat(wa);
  endfunction

  int          n_rd = 0, n_wr = 0, op_no = 0, rd_op = 0, wr_op = 0;
  logic [23:0] last_rd = '0, last_wr = '0, m_base;
  logic [31:0] wr_beats [WORDS];
  bit          m_we;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        m_base = mem_addr;
        m_we   = mem_we;
        @(negedge clk);
        // R10: request still held and unchanged while waiting for acknowledge
        check(mem_req && mem_addr == m_base && mem_we == m_we, "R10 request held", {8'd0, mem_addr}, {8'd0, m_base});
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        op_no++;
        if (m_we) begin
          n_wr++; last_wr = m_base; wr_op = op_no;
          for (int k = 0; k < WORDS; k++) begin
            while (!mem_wvalid) @(negedge clk);
            wr_beats[k] = mem_wdata;
            ram[int'({10'd0, m_base[23:2]}) + k] = mem_wdata;
            @(negedge clk);
          end
        end else begin
          n_rd++; last_rd = m_base; rd_op = op_no;
          for (int k = 0; k < WORDS; k++) begin
            mem_rvalid = 1'b1;
            mem_rdata  = ram_rd({10'd0, m_base[23:2]} + k);
            @(negedge clk);
          end
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor: compares every completed read
  always begin
    @(negedge clk);
    #2;
    if (rst_n && req_valid && !req_write && !req_stall) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 read with no expected item", req_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(req_rdata === e, "R5 read data", req_rdata, e);
      end
    end
  end

  // driver: presents one request, holds it through the stall
  task automatic access(input bit wr, input logic [23:0] a, input logic [31:0] d, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (!wr) exp_q.push_back(view_rd(a));
    stalls = 0;
    #2;
    while (req_stall) begin
      stalls++;
      @(negedge clk);
      #2;
    end
    if (wr) shadow[int'({10'd0, a[23:2]})] = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    #800000;
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  localparam logic [15:0] TA = 16'h0A01, TB = 16'h0B02, TC = 16'h0C03, TD = 16'h0D04;
  localparam logic [15:0] TE = 16'h0E05, TF = 16'h0F06, TG = 16'h1107;

  initial begin
    int st, wr0, rd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R2: reset state
    check(!req_stall && !mem_req && !mem_wvalid, "R2 idle after reset", {29'd0, req_stall, mem_req, mem_wvalid}, 32'h0);

    // R2 R5 R6: cold read miss, fill from line base
    access(0, mk(TA, 4'd3, 2'd1), 32'h0, st);
    check(st > 0, "R2 first access misses", st, 1);
    check(n_rd == 1 && last_rd == mk(TA, 4'd3, 2'd0), "R6 fill at line base", {8'd0, last_rd}, {8'd0, mk(TA, 4'd3, 2'd0)});

    // R3 R1: hit in same line, byte offset ignored
    access(0, mk(TA, 4'd3, 2'd3) | 24'd2, 32'h0, st);
    check(st == 0, "R3 hit without stall", st, 0);
    check(n_rd == 1, "R1 byte offset ignored", n_rd, 1);

    // R1: same tag in another set misses
    access(0, mk(TA, 4'd4, 2'd0), 32'h0, st);
    check(st > 0 && n_rd == 2, "R1 set index separates lines", st, 1);

    // R4: write hit stays local
    access(1, mk(TA, 4'd3, 2'd2), 32'hDEAD_0001, st);
    check(st == 0 && n_rd == 2 && n_wr == 0, "R4 write hit no traffic", st, 0);
    access(0, mk(TA, 4'd3, 2'd2), 32'h0, st);
    check(st == 0, "R4 read back hits", st, 0);

    // fill the rest of set 3
    access(0, mk(TB, 4'd3, 2'd0), 32'h0, st);
    access(0, mk(TC, 4'd3, 2'd0), 32'h0, st);
    access(0, mk(TD, 4'd3, 2'd0), 32'h0, st);
    check(n_rd == 5 && n_wr == 0, "R7 filling free ways no write-back", n_wr, 0);

    // R9: touch A so B becomes least recent, then miss with E
    access(0, mk(TA, 4'd3, 2'd0), 32'h0, st);
    access(0, mk(TE, 4'd3, 2'd1), 32'h0, st);
    check(n_wr == 0, "R7 clean victim not written back", n_wr, 0);
    access(0, mk(TA, 4'd3, 2'd1), 32'h0, st);
    check(st == 0, "R9 recent way kept", st, 0);
    access(0, mk(TB, 4'd3, 2'd1), 32'h0, st);
    check(st > 0, "R9 least recent way evicted", st, 1);

    // R8: make dirty A the least recent, then evict it
    access(0, mk(TD, 4'd3, 2'd0), 32'h0, st);
    access(0, mk(TE, 4'd3, 2'd0), 32'h0, st);
    access(0, mk(TB, 4'd3, 2'd0), 32'h0, st);
    check(st == 0, "R9 touches hit", st, 0);
    wr0 = n_wr; rd0 = n_rd;
    access(0, mk(TF, 4'd3, 2'd0), 32'h0, st);
    check(n_wr == wr0 + 1 && last_wr == mk(TA, 4'd3, 2'd0), "R8 dirty victim written at base", {8'd0, last_wr}, {8'd0, mk(TA, 4'd3, 2'd0)});
    check(wr_beats[2] == 32'hDEAD_0001, "R8 written word in beat 2", wr_beats[2], 32'hDEAD_0001);
    check(wr_beats[0] == pat({10'd0, mk(TA, 4'd3, 2'd0) >> 2}), "R8 ascending beat 0", wr_beats[0], pat({10'd0, mk(TA, 4'd3, 2'd0) >> 2}));
    check(n_rd == rd0 + 1 && rd_op == wr_op + 1, "R8 write-back before fill", rd_op, wr_op + 1);
    // refetch: data must come back from RAM with the write-back merged
    access(0, mk(TA, 4'd3, 2'd2), 32'h0, st);
    check(st > 0, "R8 evicted line misses", st, 1);

    // R11: write miss in set 5, merge, then evict
    rd0 = n_rd;
    access(1, mk(TG, 4'd5, 2'd1), 32'h1234_5678, st);
    check(st > 0 && n_rd == rd0 + 1, "R11 write miss fills", st, 1);
    access(0, mk(TG, 4'd5, 2'd1), 32'h0, st);
    check(st == 0, "R11 merged word hits", st, 0);
    access(0, mk(TG, 4'd5, 2'd0), 32'h0, st);
    access(0, mk(TB, 4'd5, 2'd0), 32'h0, st);
    access(0, mk(TC, 4'd5, 2'd0), 32'h0, st);
    access(0, mk(TD, 4'd5, 2'd0), 32'h0, st);
    wr0 = n_wr;
    access(0, mk(TE, 4'd5, 2'd0), 32'h0, st);
    check(n_wr == wr0 + 1 && last_wr == mk(TG, 4'd5, 2'd0), "R11 dirty after write miss", {8'd0, last_wr}, {8'd0, mk(TG, 4'd5, 2'd0)});
    check(wr_beats[1] == 32'h1234_5678, "R11 merged word written back", wr_beats[1], 32'h1234_5678);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule